// File: doc/BRIEF.md
# Chained Device Selector

Each device in a chain of identical memory devices carries one copy of this block. The block keeps two 16-bit registers written from the host's low data lane. The first is a page address, unique to this device. The second is a select value, which the host writes to every device at once. A device is addressed when the select value equals its page address. The all-ones select value addresses every device together. In that broadcast state writes still reach every device, but no device may drive the shared read bus.

The block decides, one cycle after each read request, whether this device drives the read bus. There are two kinds of read request:

- A register read returns the page address or the select value. The upper half of the read word is zero.
- A next-free query returns an address value supplied from outside the block. It works in one of two ways, chosen by the enable-compare input:
  - With enable-compare low, the query is chain-gated. Only the first device that still has room answers. That device sees its full-in input low, meaning every device upstream is full, and its own not-full flag high.
  - With enable-compare high, only the device whose page address matches the select value answers.

The output-enable is the only gate on the read bus. When it is low, the read data is all zeros.

Top module: `chain_dev_sel`

## Requirements
- R1: After the asynchronous reset (rst_ni low), the page address and the select value are both 0. So sel_o is 1, bcast_o is 0 and rdata_oe_o is 0.
- R2: When wr_i is 1 and wr_sel_i is 0, wdata_i is written into the page address at the next clock. The value FFFFh is rejected and leaves the page address unchanged.
- R3: When wr_i is 1 and wr_sel_i is 1, wdata_i is written into the select value at the next clock. This write is accepted whether or not the device is currently selected.
- R4: sel_o is 1 when the select value equals the page address or equals FFFFh. bcast_o is 1 exactly when the select value is FFFFh.
- R5: Register read codes on rd_op_i are 01 for the page address and 10 for the select value. If the device is selected and not in broadcast, then one cycle after the read rdata_oe_o is 1. At that point rdata_o holds 16 zero bits followed by the register value.
- R6: A register read when the device is not selected, or when it is in broadcast, gives rdata_oe_o = 0 on the following cycle.
- R7: A next-free query is rd_op_i = 11. With cmp_en_i = 0, the device drives the bus on the next cycle only if chain_full_ni = 0 and dev_full_ni = 1. When it drives, rdata_o is 16 zero bits followed by nf_addr_i.
- R8: A next-free query with cmp_en_i = 1 drives the bus on the next cycle only if the select value equals the page address. A broadcast select value therefore never drives.
- R9: rdata_o is all zeros whenever rdata_oe_o is 0. rdata_oe_o is 1 only in the cycle after a read request (rd_op_i other than 00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 is the page address, 1 is the select value |
| wdata_i | input | 16 | Write data from the low data lane |
| rd_op_i | input | 2 | Read request: 00 idle, 01 page address, 10 select value, 11 next-free query |
| cmp_en_i | input | 1 | Query mode: 0 is chain-gated, 1 is compare |
| chain_full_ni | input | 1 | Low when every upstream device is full |
| dev_full_ni | input | 1 | High when this device has room |
| nf_addr_i | input | 16 | Next-free address value to return on a query |
| sel_o | output | 1 | This device is addressed |
| bcast_o | output | 1 | The broadcast select value is active |
| rdata_oe_o | output | 1 | This device drives the read bus |
| rdata_o | output | 32 | Read data, all zeros when not driving |

## Verification
The hardest states to reach from the ports are those where the select value and the page address relate in a particular way. The clearest case is a broadcast select while a query is running in compare mode, because both registers can only be reached through writes. The stimulus builds each state by writing the page address first and then moving the select value through match, mismatch and all-ones. After each step it issues reads and both kinds of query. An attempt to write FFFFh as the page address comes between two reads of that register, so that the rejection shows up at the read port.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_RD_PA = 2'b01,
    OP_RD_DS = 2'b10,
    OP_NF    = 2'b11
  } rd_op_e;

  typedef enum logic {
    REG_PA = 1'b0,
    REG_DS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cds_regs.sv
module cds_regs
  import cds_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          wr_sel_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] pa_o,
  output logic [AW-1:0] ds_o
);
  localparam logic [AW-1:0] ALL_ONES = '1;

  logic pa_we, ds_we;

  assign pa_we = wr_i && (reg_sel_e'(wr_sel_i) == REG_PA) && (wdata_i != ALL_ONES);
  assign ds_we = wr_i && (reg_sel_e'(wr_sel_i) == REG_DS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_o <= '0;
      ds_o <= '0;
    end else begin
      if (pa_we) pa_o <= wdata_i;
      if (ds_we) ds_o <= wdata_i;
    end
  end

  // R2: the page address never holds the reserved all-ones value
  a_r2_pa_never_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_o != ALL_ONES);

  // R2: a rejected write leaves the page address unchanged
  a_r2_reject_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_sel_i && wdata_i == ALL_ONES) |=> $stable(pa_o));

  // R3: a select write always lands
  a_r3_ds_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_sel_i) |=> (ds_o == $past(wdata_i)));
endmodule

// File: rtl/cds_match.sv
module cds_match #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] pa_i,
  input  logic [AW-1:0] ds_i,
  output logic          match_o,
  output logic          bcast_o,
  output logic          sel_o
);
  localparam logic [AW-1:0] ALL_ONES = '1;

  always_comb begin
    match_o = (ds_i == pa_i);
    bcast_o = (ds_i == ALL_ONES);
    sel_o   = match_o || bcast_o;
  end
endmodule

// File: rtl/cds_drive.sv
module cds_drive
  import cds_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    rd_op_i,
  input  logic          cmp_en_i,
  input  logic          chain_full_ni,
  input  logic          dev_full_ni,
  input  logic [AW-1:0] nf_addr_i,
  input  logic [AW-1:0] pa_i,
  input  logic [AW-1:0] ds_i,
  input  logic          sel_i,
  input  logic          bcast_i,
  input  logic          match_i,
  output logic          oe_o,
  output logic [DW-1:0] rdata_o
);
  localparam int PAD = DW - AW;

  rd_op_e        op;
  logic          drive_d;
  logic [AW-1:0] val_d;
  logic [DW-1:0] word_d;

  assign op = rd_op_e'(rd_op_i);

  always_comb begin
    drive_d = 1'b0;
    val_d   = '0;
    unique case (op)
      OP_RD_PA: begin
        drive_d = sel_i && !bcast_i;
        val_d   = pa_i;
      end
      OP_RD_DS: begin
        drive_d = sel_i && !bcast_i;
        val_d   = ds_i;
      end
      OP_NF: begin
        // chain-gated: first device with room behind a full upstream
        drive_d = cmp_en_i ? (match_i && !bcast_i) : (!chain_full_ni && dev_full_ni);
        val_d   = nf_addr_i;
      end
      default: begin
        drive_d = 1'b0;
        val_d   = '0;
      end
    endcase
  end

  generate
    if (PAD > 0) begin : g_pad
      assign word_d = drive_d ? {{PAD{1'b0}}, val_d} : '0;
    end else begin : g_nopad
      assign word_d = drive_d ? val_d[DW-1:0] : '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o    <= 1'b0;
      rdata_o <= '0;
    end else begin
      oe_o    <= drive_d;
      rdata_o <= word_d;
    end
  end

  // R9: a silent bus carries zeros
  a_r9_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (rdata_o == '0));

  // R9: driving only follows a read request
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_op_i == OP_IDLE) |=> !oe_o);

  // R6: broadcast blocks register reads
  a_r6_bcast_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcast_i && (rd_op_i == OP_RD_PA || rd_op_i == OP_RD_DS)) |=> !oe_o);

  // R7: the first non-full device answers a chain-gated query
  a_r7_chain_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_op_i == OP_NF && !cmp_en_i && !chain_full_ni && dev_full_ni)
      |=> (oe_o && rdata_o[AW-1:0] == $past(nf_addr_i)));

  // R8: a compare-mode query never answers while broadcasting
  a_r8_bcast_no_nf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_op_i == OP_NF && cmp_en_i && bcast_i) |=> !oe_o);
endmodule

// File: rtl/chain_dev_sel.sv
module chain_dev_sel #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          wr_sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [1:0]    rd_op_i,
  input  logic          cmp_en_i,
  input  logic          chain_full_ni,
  input  logic          dev_full_ni,
  input  logic [AW-1:0] nf_addr_i,
  output logic          sel_o,
  output logic          bcast_o,
  output logic          rdata_oe_o,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] pa_q, ds_q;
  logic          match;

  cds_regs #(.AW(AW)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .wr_sel_i (wr_sel_i),
    .wdata_i  (wdata_i),
    .pa_o     (pa_q),
    .ds_o     (ds_q)
  );

  cds_match #(.AW(AW)) i_match (
    .pa_i    (pa_q),
    .ds_i    (ds_q),
    .match_o (match),
    .bcast_o (bcast_o),
    .sel_o   (sel_o)
  );

  cds_drive #(.AW(AW), .DW(DW)) i_drive (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_op_i       (rd_op_i),
    .cmp_en_i      (cmp_en_i),
    .chain_full_ni (chain_full_ni),
    .dev_full_ni   (dev_full_ni),
    .nf_addr_i     (nf_addr_i),
    .pa_i          (pa_q),
    .ds_i          (ds_q),
    .sel_i         (sel_o),
    .bcast_i       (bcast_o),
    .match_i       (match),
    .oe_o          (rdata_oe_o),
    .rdata_o       (rdata_o)
  );

  // R4: writing the own page address into the select value addresses this device
  a_r4_select_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_sel_i && wdata_i == pa_q && !(wr_i && !wr_sel_i)) |=> sel_o);

  // R4: writing all ones into the select value enters broadcast
  a_r4_bcast_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_sel_i && wdata_i == '1) |=> (bcast_o && sel_o));
endmodule

// File: tb/test_chain_dev_sel.sv
module test_chain_dev_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, wsel = 1'b0;
  logic [15:0] wdata = '0;
  logic [1:0]  op = 2'b00;
  logic        cmp = 1'b0, chn = 1'b1, dvn = 1'b0;
  logic [15:0] nf = '0;
  logic        sel, bcast, oe;
  logic [31:0] rdata;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  chain_dev_sel i_chain_dev_sel (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_sel_i(wsel), .wdata_i(wdata),
    .rd_op_i(op), .cmp_en_i(cmp), .chain_full_ni(chn), .dev_full_ni(dvn),
    .nf_addr_i(nf), .sel_o(sel), .bcast_o(bcast), .rdata_oe_o(oe), .rdata_o(rdata)
  );

  typedef struct packed {
    logic        wr;
    logic        wsel;
    logic [15:0] wd;
    logic [1:0]  op;
    logic        cmp;
    logic        chn;
    logic        dvn;
    logic [15:0] nf;
    logic        esel;
    logic        ebc;
    logic        eoe;
    logic [15:0] erd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h0012, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd2}, // R2 load page
    '{1'b0, 1'b0, 16'h0000, 2'b01, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd6}, // R6 unselected read
    '{1'b1, 1'b1, 16'h0012, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd3}, // R3 select write
    '{1'b0, 1'b0, 16'h0000, 2'b01, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0012, 4'd5}, // R5 page read
    '{1'b0, 1'b0, 16'h0000, 2'b10, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0012, 4'd5}, // R5 select read
    '{1'b1, 1'b0, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd2}, // R2 all-ones rejected
    '{1'b0, 1'b0, 16'h0000, 2'b01, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0012, 4'd2}, // R2 page kept
    '{1'b1, 1'b1, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 4'd4}, // R4 broadcast
    '{1'b0, 1'b0, 16'h0000, 2'b10, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 4'd6}, // R6 broadcast read muted
    '{1'b0, 1'b0, 16'h0000, 2'b11, 1'b1, 1'b1, 1'b1, 16'h0345, 1'b1, 1'b1, 1'b0, 16'h0000, 4'd8}, // R8 broadcast query
    '{1'b0, 1'b0, 16'h0000, 2'b11, 1'b0, 1'b0, 1'b1, 16'h0345, 1'b1, 1'b1, 1'b1, 16'h0345, 4'd7}, // R7 first free
    '{1'b0, 1'b0, 16'h0000, 2'b11, 1'b0, 1'b1, 1'b1, 16'h0345, 1'b1, 1'b1, 1'b0, 16'h0000, 4'd7}, // R7 upstream has room
    '{1'b0, 1'b0, 16'h0000, 2'b11, 1'b0, 1'b0, 1'b0, 16'h0345, 1'b1, 1'b1, 1'b0, 16'h0000, 4'd7}, // R7 self full
    '{1'b1, 1'b1, 16'h0012, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd4}, // R4 leave broadcast
    '{1'b0, 1'b0, 16'h0000, 2'b11, 1'b1, 1'b1, 1'b0, 16'h0777, 1'b1, 1'b0, 1'b1, 16'h0777, 4'd8}, // R8 compare hit
    '{1'b1, 1'b1, 16'h0013, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd4}, // R4 mismatch
    '{1'b0, 1'b0, 16'h0000, 2'b11, 1'b1, 1'b0, 1'b1, 16'h0777, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd8}, // R8 compare miss
    '{1'b1, 1'b0, 16'h0013, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd4}, // R4 page follows
    '{1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 16'h0555, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd9}  // R9 idle quiet
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic ws, input logic [15:0] wd,
                      input logic [1:0] o, input logic c, input logic ch,
                      input logic dv, input logic [15:0] n);
    wr = w; wsel = ws; wdata = wd; op = o; cmp = c; chn = ch; dvn = dv; nf = n;
    @(negedge clk);
    wr = 1'b0; op = 2'b00;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sel", {31'd0, sel}, 32'd1);
    chk("R1 bcast", {31'd0, bcast}, 32'd0);
    chk("R1 oe", {31'd0, oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].wsel, VECS[i].wd, VECS[i].op,
           VECS[i].cmp, VECS[i].chn, VECS[i].dvn, VECS[i].nf);
      chk($sformatf("R%0d sel v%0d", VECS[i].rq, i), {31'd0, sel}, {31'd0, VECS[i].esel});
      chk($sformatf("R%0d bcast v%0d", VECS[i].rq, i), {31'd0, bcast}, {31'd0, VECS[i].ebc});
      chk($sformatf("R%0d oe v%0d", VECS[i].rq, i), {31'd0, oe}, {31'd0, VECS[i].eoe});
      chk($sformatf("R%0d rdata v%0d", VECS[i].rq, i), rdata, {16'h0000, VECS[i].erd});
    end

    // R5: upper half of a register read is zero, low half is the full value
    step(1'b1, 1'b0, 16'hABCD, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0);
    step(1'b1, 1'b1, 16'hABCD, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0);
    step(1'b0, 1'b0, 16'h0, 2'b01, 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R5 wide page read", rdata, 32'h0000ABCD);

    // R9: data drops back to zero the cycle after the read
    @(negedge clk);
    chk("R9 oe drop", {31'd0, oe}, 32'd0);
    chk("R9 data drop", rdata, 32'd0);

    // R3: select write accepted while not addressed
    step(1'b1, 1'b1, 16'h0001, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R3 deselected", {31'd0, sel}, 32'd0);
    step(1'b1, 1'b1, 16'hABCD, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R3 reselected", {31'd0, sel}, 32'd1);

    // R1: reset in mid-run clears both registers
    rst_n = 1'b0;
    #1;
    chk("R1 oe async", {31'd0, oe}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 16'h0, 2'b10, 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R1 select cleared", rdata, 32'd0);
    chk("R1 oe on match", {31'd0, oe}, 32'd1);
    chk("R1 sel after reset", {31'd0, sel}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule